// File: doc/BRIEF.md
# Calibrated Seconds Real-Time Counter

This core keeps wall-clock time as a plain 32-bit count of seconds. It is placed on a simple register bus with a setup phase and an access phase. A slow crystal oscillator reaches it as a one-cycle strobe that is already synchronous to the core clock. Each second lasts a programmable number of strobes. An optional fractional correction stretches some seconds by one strobe, so a crystal whose rate is not a whole number per second still keeps long-term accuracy. Software converts between calendar dates and the seconds count.

The core compares the running count with an alarm value. It records two events, a once-per-second event and an alarm event, in a sticky status register that software clears by writing ones. Each event drives its own interrupt line, which is gated by a mask. Software sets mask bits through an enable register and clears them through a disable register. The whole core runs on one clock.

Top module: `secrtc_core`

## Requirements
- R1: A write to offset 0x00 loads the seconds counter with the full 32-bit word. Any value up to 0xFFFFFFFF is accepted, and counting past 0xFFFFFFFF wraps to 0. The seconds count reads at 0x10, and the last loaded word reads back at 0x04.
- R2: The sub-second tick counter, readable at 0x14, advances once per oscillator strobe. When the strobe that completes the programmed tick count N (calibration bits 15:0) arrives, the seconds count increments and the tick counter returns to 0. A second is therefore N strobes long.
- R3: When calibration bit 20 is 1, seconds 0..F-1 of every group of 16 seconds last N+1 strobes, where F is calibration bits 19:16. The 16-second phase starts at the last time load. When bit 20 is 0, the value of F has no effect.
- R4: After reset the calibration register reads 0x198233 at 0x0C. The seconds count, tick count, alarm, status and mask all read 0, and both interrupt lines are low.
- R5: The calibration register is written at 0x08 and keeps only bits 20:0. Bits 31:21 of its readback are always 0.
- R6: Status at 0x20 holds bit 0 for the per-second event and bit 1 for the alarm event. A bit is set on its event even while masked. Writing 1 to a bit clears it, and writing 0 leaves it unchanged.
- R7: Writing 1s to 0x28 sets mask bits, and writing 1s to 0x2C clears them. The mask reads at 0x24 with 1 meaning enabled. irq_second equals status bit 0 AND mask bit 0, and irq_alarm equals status bit 1 AND mask bit 1.
- R8: A time load also clears the tick counter and the fractional phase, so the next second is a full one.
- R9: The alarm value is read and written at 0x18. The alarm event is raised on the strobe that increments the seconds count to a value equal to the alarm. A time load does not raise it.
- R10: When an event and a write-1 clear of the same status bit happen in the same cycle, the event wins and the bit stays set. Other bits in the same write are still cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_tick | input | 1 | One-cycle oscillator strobe |
| bus_sel | input | 1 | Peripheral select |
| bus_en | input | 1 | Access phase qualifier |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid during the access phase |
| irq_second | output | 1 | Per-second interrupt |
| irq_alarm | output | 1 | Alarm interrupt |

## Verification
The hardest case to reach from the ports is a status clear that lands in the same cycle as a fresh event. The bench sets a calibration of one strobe per second, so any single strobe completes a second. It then raises the strobe during the access phase of the status write, so both reach the same clock edge. It checks that the per-second bit survives and that the alarm bit written in the same word is cleared. A second hard case is the fractional correction. The bench reloads the time to reset the 16-second phase, then counts strobes across several seconds to see which seconds are lengthened.

// File: rtl/secrtc_pkg.sv
package secrtc_pkg;
  localparam int unsigned ADDR_W = 8;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned NIRQ   = 2;

  localparam logic [ADDR_W-1:0] OFS_TIME_LD  = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_TIME_RB  = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_CAL_WR   = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_CAL_RB   = 8'h0C;
  localparam logic [ADDR_W-1:0] OFS_SECONDS  = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_TICKS    = 8'h14;
  localparam logic [ADDR_W-1:0] OFS_ALARM    = 8'h18;
  localparam logic [ADDR_W-1:0] OFS_STATUS   = 8'h20;
  localparam logic [ADDR_W-1:0] OFS_MASK     = 8'h24;
  localparam logic [ADDR_W-1:0] OFS_ENABLE   = 8'h28;
  localparam logic [ADDR_W-1:0] OFS_DISABLE  = 8'h2C;

  typedef enum int unsigned {
    EV_SECOND = 0,
    EV_ALARM  = 1
  } ev_idx_e;
endpackage

// File: rtl/secrtc_timebase.sv
module secrtc_timebase #(
  parameter int unsigned SEC_W  = 32,
  parameter int unsigned TICK_W = 16,
  parameter int unsigned FRAC_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe,
  input  logic              load,
  input  logic [SEC_W-1:0]  load_val,
  input  logic [TICK_W-1:0] cal_count,
  input  logic [FRAC_W-1:0] cal_frac,
  input  logic              cal_fen,
  input  logic [SEC_W-1:0]  alarm_val,
  output logic [SEC_W-1:0]  seconds,
  output logic [TICK_W-1:0] ticks,
  output logic              sec_evt,
  output logic              alm_evt
);
  localparam int unsigned CMP_W = TICK_W + 1;

  logic [SEC_W-1:0]  sec_q, sec_d;
  logic [TICK_W-1:0] tick_q, tick_d;
  logic [FRAC_W-1:0] ph_q, ph_d;
  logic [CMP_W-1:0]  target, tick_inc;
  logic              stretch, wrap;
  logic [SEC_W-1:0]  sec_plus;

  always_comb begin
    stretch  = cal_fen && (ph_q < cal_frac);
    target   = {1'b0, cal_count} + CMP_W'(stretch);
    tick_inc = {1'b0, tick_q} + CMP_W'(1);
    wrap     = strobe && (tick_inc >= target);
    sec_plus = sec_q + SEC_W'(1);
    sec_d    = sec_q;
    tick_d   = tick_q;
    ph_d     = ph_q;
    if (load) begin
      sec_d  = load_val;
      tick_d = '0;
      ph_d   = '0;
    end else if (wrap) begin
      sec_d  = sec_plus;
      tick_d = '0;
      ph_d   = ph_q + FRAC_W'(1);
    end else if (strobe) begin
      tick_d = tick_inc[TICK_W-1:0];
    end
    sec_evt = wrap && !load;
    alm_evt = sec_evt && (sec_plus == alarm_val);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_q  <= '0;
      tick_q <= '0;
      ph_q   <= '0;
    end else begin
      sec_q  <= sec_d;
      tick_q <= tick_d;
      ph_q   <= ph_d;
    end
  end

  assign seconds = sec_q;
  assign ticks   = tick_q;

  assert_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (seconds == $past(load_val)));
  assert_load_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (ticks == '0));
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !strobe) |=> ($stable(seconds) && $stable(ticks)));
  assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sec_evt |=> (seconds == $past(seconds) + SEC_W'(1)));
endmodule

// File: rtl/secrtc_irq.sv
module secrtc_irq #(
  parameter int unsigned NEV = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NEV-1:0] evt,
  input  logic           clr_we,
  input  logic           en_we,
  input  logic           dis_we,
  input  logic [NEV-1:0] wbits,
  output logic [NEV-1:0] status,
  output logic [NEV-1:0] mask,
  output logic [NEV-1:0] irq
);
  logic [NEV-1:0] sts_q, sts_d, msk_q, msk_d;

  for (genvar i = 0; i < NEV; i++) begin : g_bit
    always_comb begin
      sts_d[i] = sts_q[i];
      if (clr_we && wbits[i]) sts_d[i] = 1'b0;
      if (evt[i])             sts_d[i] = 1'b1;
      msk_d[i] = msk_q[i];
      if (en_we && wbits[i])  msk_d[i] = 1'b1;
      if (dis_we && wbits[i]) msk_d[i] = 1'b0;
    end
    assign irq[i] = sts_q[i] & msk_q[i];

    assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      evt[i] |=> status[i]);
    assert_w1c_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_we && wbits[i] && !evt[i]) |=> !status[i]);
    assert_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (en_we && wbits[i]) |=> mask[i]);
    assert_disable_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (dis_we && wbits[i]) |=> (!mask[i] && !irq[i]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_q <= '0;
      msk_q <= '0;
    end else begin
      sts_q <= sts_d;
      msk_q <= msk_d;
    end
  end

  assign status = sts_q;
  assign mask   = msk_q;
endmodule

// File: rtl/secrtc_core.sv
module secrtc_core
  import secrtc_pkg::*;
#(
  parameter int unsigned SEC_W   = 32,
  parameter int unsigned TICK_W  = 16,
  parameter int unsigned FRAC_W  = 4,
  parameter logic [31:0] CAL_RST = 32'h0019_8233
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              osc_tick,
  input  logic              bus_sel,
  input  logic              bus_en,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_second,
  output logic              irq_alarm
);
  localparam int unsigned CAL_W  = TICK_W + FRAC_W + 1;
  localparam int unsigned FEN_B  = TICK_W + FRAC_W;

  logic              acc, wr;
  logic              we_time, we_cal, we_alarm, we_clr, we_en, we_dis;
  logic [SEC_W-1:0]  time_q, time_d, alarm_q, alarm_d;
  logic [CAL_W-1:0]  cal_q, cal_d;
  logic [SEC_W-1:0]  seconds;
  logic [TICK_W-1:0] ticks;
  logic              sec_evt, alm_evt;
  logic [NIRQ-1:0]   evt, status, mask, irq;

  always_comb begin
    acc      = bus_sel && bus_en;
    wr       = acc && bus_wr;
    we_time  = wr && (bus_addr == OFS_TIME_LD);
    we_cal   = wr && (bus_addr == OFS_CAL_WR);
    we_alarm = wr && (bus_addr == OFS_ALARM);
    we_clr   = wr && (bus_addr == OFS_STATUS);
    we_en    = wr && (bus_addr == OFS_ENABLE);
    we_dis   = wr && (bus_addr == OFS_DISABLE);
    time_d   = we_time  ? bus_wdata[SEC_W-1:0] : time_q;
    cal_d    = we_cal   ? bus_wdata[CAL_W-1:0] : cal_q;
    alarm_d  = we_alarm ? bus_wdata[SEC_W-1:0] : alarm_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      time_q  <= '0;
      cal_q   <= CAL_RST[CAL_W-1:0];
      alarm_q <= '0;
    end else begin
      time_q  <= time_d;
      cal_q   <= cal_d;
      alarm_q <= alarm_d;
    end
  end

  secrtc_timebase #(
    .SEC_W (SEC_W),
    .TICK_W(TICK_W),
    .FRAC_W(FRAC_W)
  ) u_tb (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe   (osc_tick),
    .load     (we_time),
    .load_val (bus_wdata[SEC_W-1:0]),
    .cal_count(cal_q[TICK_W-1:0]),
    .cal_frac (cal_q[FEN_B-1:TICK_W]),
    .cal_fen  (cal_q[FEN_B]),
    .alarm_val(alarm_q),
    .seconds  (seconds),
    .ticks    (ticks),
    .sec_evt  (sec_evt),
    .alm_evt  (alm_evt)
  );

  always_comb begin
    evt            = '0;
    evt[EV_SECOND] = sec_evt;
    evt[EV_ALARM]  = alm_evt;
  end

  secrtc_irq #(.NEV(NIRQ)) u_irq (
    .clk   (clk),
    .rst_n (rst_n),
    .evt   (evt),
    .clr_we(we_clr),
    .en_we (we_en),
    .dis_we(we_dis),
    .wbits (bus_wdata[NIRQ-1:0]),
    .status(status),
    .mask  (mask),
    .irq   (irq)
  );

  assign irq_second = irq[EV_SECOND];
  assign irq_alarm  = irq[EV_ALARM];

  always_comb begin
    bus_rdata = '0;
    if (acc && !bus_wr) begin
      case (bus_addr)
        OFS_TIME_RB: bus_rdata = DATA_W'(time_q);
        OFS_CAL_RB:  bus_rdata = DATA_W'(cal_q);
        OFS_SECONDS: bus_rdata = DATA_W'(seconds);
        OFS_TICKS:   bus_rdata = DATA_W'(ticks);
        OFS_ALARM:   bus_rdata = DATA_W'(alarm_q);
        OFS_STATUS:  bus_rdata = DATA_W'(status);
        OFS_MASK:    bus_rdata = DATA_W'(mask);
        default:     bus_rdata = '0;
      endcase
    end
  end

  assert_cal_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
    we_cal |=> (cal_q == $past(bus_wdata[CAL_W-1:0])));
  assert_alarm_wr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    we_alarm |=> (alarm_q == $past(bus_wdata[SEC_W-1:0])));
endmodule

// File: tb/tb_secrtc_core.sv
module tb_secrtc_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        osc_tick = 1'b0;
  logic        bus_sel = 1'b0, bus_en = 1'b0, bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_second, irq_alarm;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  secrtc_core dut (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick),
    .bus_sel(bus_sel), .bus_en(bus_en), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_second(irq_second), .irq_alarm(irq_alarm)
  );

  // monitor: pops the expected read value in the access phase
  always @(negedge clk) begin
    if (bus_sel && bus_en && !bus_wr) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_chk++;
      if (bus_rdata !== e) begin
        n_bad++;
        $display("FAIL %s: read 0x%08h expected 0x%08h", t, bus_rdata, e);
      end
    end
  end

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d,
                           input logic with_tick = 1'b0);
    @(posedge clk); #1;
    bus_sel = 1'b1; bus_wr = 1'b1; bus_en = 1'b0; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_en = 1'b1; osc_tick = with_tick;
    @(posedge clk); #1;
    bus_sel = 1'b0; bus_en = 1'b0; bus_wr = 1'b0; osc_tick = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, input logic [31:0] e,
                          input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(posedge clk); #1;
    bus_sel = 1'b1; bus_wr = 1'b0; bus_en = 1'b0; bus_addr = a;
    @(posedge clk); #1;
    bus_en = 1'b1;
    @(posedge clk); #1;
    bus_sel = 1'b0; bus_en = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1; osc_tick = 1'b1;
      @(posedge clk); #1; osc_tick = 1'b0;
    end
  endtask

  task automatic check_pin(input logic act, input logic e, input string t);
    @(negedge clk);
    n_chk++;
    if (act !== e) begin
      n_bad++;
      $display("FAIL %s: pin %0b expected %0b", t, act, e);
    end
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R4 reset state
    bus_read(8'h0C, 32'h0019_8233, "R4 cal reset");
    bus_read(8'h10, 32'h0, "R4 seconds reset");
    bus_read(8'h14, 32'h0, "R4 ticks reset");
    bus_read(8'h18, 32'h0, "R4 alarm reset");
    bus_read(8'h20, 32'h0, "R4 status reset");
    bus_read(8'h24, 32'h0, "R4 mask reset");
    check_pin(irq_second, 1'b0, "R4 irq_second reset");
    check_pin(irq_alarm, 1'b0, "R4 irq_alarm reset");
    // R1 load
    bus_write(8'h00, 32'h1234_5678);
    bus_read(8'h10, 32'h1234_5678, "R1 seconds load");
    bus_read(8'h04, 32'h1234_5678, "R1 load readback");
    // R5 calibration width
    bus_write(8'h08, 32'hFFE0_0005);
    bus_read(8'h0C, 32'h0000_0005, "R5 cal masked");
    // R2 plain counting with N=4
    bus_write(8'h08, 32'h4);
    bus_write(8'h00, 32'd100);
    ticks(3);
    bus_read(8'h14, 32'd3, "R2 ticks mid");
    bus_read(8'h10, 32'd100, "R2 seconds hold");
    ticks(1);
    bus_read(8'h10, 32'd101, "R2 seconds step");
    bus_read(8'h14, 32'd0, "R2 ticks wrap");
    // R6 sticky while masked, R7 gating
    bus_read(8'h20, 32'h1, "R6 sec status masked");
    check_pin(irq_second, 1'b0, "R7 masked line low");
    bus_write(8'h28, 32'h1);
    bus_read(8'h24, 32'h1, "R7 mask enabled");
    check_pin(irq_second, 1'b1, "R7 line high");
    bus_write(8'h20, 32'h0);
    bus_read(8'h20, 32'h1, "R6 write zero keeps");
    bus_write(8'h20, 32'h1);
    bus_read(8'h20, 32'h0, "R6 w1c");
    check_pin(irq_second, 1'b0, "R7 line after clear");
    bus_write(8'h2C, 32'h1);
    bus_read(8'h24, 32'h0, "R7 mask disabled");
    // R3 fraction disabled: F=3 ignored
    bus_write(8'h08, 32'h0003_0004);
    bus_write(8'h00, 32'd0);
    ticks(4);
    bus_read(8'h10, 32'd1, "R3 fraction off");
    // R3 fraction enabled: F=3, seconds 0..2 are 5 strobes, 3 is 4
    bus_write(8'h08, 32'h0013_0004);
    bus_write(8'h00, 32'd0);
    ticks(4);
    bus_read(8'h10, 32'd0, "R3 stretched not done");
    ticks(1);
    bus_read(8'h10, 32'd1, "R3 stretched second 0");
    ticks(5);
    bus_read(8'h10, 32'd2, "R3 stretched second 1");
    ticks(5);
    bus_read(8'h10, 32'd3, "R3 stretched second 2");
    ticks(4);
    bus_read(8'h10, 32'd4, "R3 plain second 3");
    // R8 load clears tick and phase
    ticks(2);
    bus_write(8'h00, 32'd50);
    bus_read(8'h14, 32'd0, "R8 ticks cleared");
    ticks(4);
    bus_read(8'h10, 32'd50, "R8 phase restarted");
    ticks(1);
    bus_read(8'h10, 32'd51, "R8 full second");
    // R9 alarm
    bus_write(8'h20, 32'h3);
    bus_write(8'h08, 32'h2);
    bus_write(8'h18, 32'd7);
    bus_read(8'h18, 32'd7, "R9 alarm readback");
    bus_write(8'h00, 32'd7);
    bus_read(8'h20, 32'h0, "R9 load no alarm");
    bus_write(8'h00, 32'd5);
    ticks(2);
    bus_read(8'h20, 32'h1, "R9 no alarm at 6");
    bus_write(8'h28, 32'h2);
    ticks(2);
    bus_read(8'h20, 32'h3, "R9 alarm at 7");
    check_pin(irq_alarm, 1'b1, "R9 alarm line");
    // R10 clear collides with second event
    bus_write(8'h08, 32'h1);
    bus_write(8'h20, 32'h3, 1'b1);
    bus_read(8'h20, 32'h1, "R10 event wins clear");
    check_pin(irq_alarm, 1'b0, "R10 alarm cleared");
    // R1 wrap
    bus_write(8'h00, 32'hFFFF_FFFF);
    bus_read(8'h10, 32'hFFFF_FFFF, "R1 max value");
    ticks(1);
    bus_read(8'h10, 32'h0, "R1 wrap");
    repeat (4) @(posedge clk);
    if (exp_q.size() != 0) begin
      n_chk++; n_bad++;
      $display("FAIL scoreboard: %0d left expected 0", exp_q.size());
    end
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule